// File: doc/BRIEF.md
# SMM-Aware Memory Request Decoder

This block sits at the entry of a host memory controller and decides where each memory request goes. A request carries an address, a source code (processor, PCI Express or the downstream legacy link), the processor's system-management-mode and write-back attributes, a read/write flag and byte enables. From these and a small set of configuration inputs it picks one of three routes. A request can go to DRAM, it can go to the downstream link, or it can go to DRAM as a neutralised invalid access whose address is forced to zero and, for writes, whose byte enables are cleared.

The configuration inputs are a legacy-hole enable for the window 15 MB to 16 MB, an enable and a size code for the protected segment at the top of low memory, an extended-protection enable, and the top-of-low-usable-memory boundary (TOLUD). Requests pass through one registered valid/ready stage. The stage is a two-state machine. `ST_EMPTY` raises `in_ready` and, when `in_valid` is high, takes `EMPTY_TO_FULL`. `ST_FULL` drives `out_valid`. On `out_ready` together with a new `in_valid` it reloads and stays in `ST_FULL` (`FULL_REFILL`). On `out_ready` without a new request it takes `FULL_TO_EMPTY`. Without `out_ready` it holds (`FULL_STALL`). The configuration is captured on the same edge as the request, and decoding is done from the captured copy.

Top module: `smm_addr_decoder`

## Requirements
- R1: With `cfg_hole_en`=1, a request with address in 0x00F0_0000..0x00FF_FFFF is routed downstream with unchanged address and byte enables. With `cfg_hole_en`=0 the same address is decoded like any other address.
- R2: A request with address at or above `cfg_tolud` that is not in an open hole is routed downstream, unchanged.
- R3: The protected segment spans [`cfg_tolud` - size, `cfg_tolud`). The size is 1 MB for `cfg_tseg_size`=00, 2 MB for 01, and 8 MB for 10 or 11.
- R4: With `cfg_tseg_en`=0, an address below `cfg_tolud` and outside an open hole is routed to DRAM, unchanged, for every source.
- R5: A non-processor request (`in_src` 01 PCI Express, 10 or 11 downstream link) that hits the enabled segment is routed as invalid. Its address becomes 0. Its byte enables become 0 for writes and are kept for reads.
- R6: A processor request (`in_src`=00) with `in_smm`=1 that hits the enabled segment goes to DRAM unchanged, except when `in_wb`=0 and `cfg_ext_smram`=1, in which case it is routed as invalid.
- R7: A processor request with `in_smm`=0 that hits the enabled segment goes to DRAM unchanged when `in_wb`=1 (coherency write-back). Otherwise it is routed as invalid.
- R8: `out_route` is 00 for DRAM, 01 for downstream and 10 for invalid-DRAM; 11 never appears. Non-invalid routes carry the request's address and byte enables unchanged. `out_write` always echoes the request's flag.
- R9: Decode priority is: open hole first, then at-or-above TOLUD, then the protected segment, then plain DRAM.
- R10: `in_ready` is high when the stage is empty or `out_ready` is high. An accepted request appears on `out_valid` after exactly one clock edge. While `out_valid`=1 and `out_ready`=0, all outputs hold stable.
- R11: The configuration used for a request is the value present on the edge that accepts it. Later changes do not alter a request that is waiting in the stage.
- R12: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Stage can take a request |
| in_addr | input | 32 | Request byte address |
| in_src | input | 2 | Source: 00 processor, 01 PCI Express, 10/11 downstream link |
| in_smm | input | 1 | System-management-mode attribute |
| in_wb | input | 1 | Write-back attribute |
| in_write | input | 1 | 1 for write, 0 for read |
| in_be | input | 8 | Byte enables |
| cfg_hole_en | input | 1 | Opens the 15–16 MB legacy hole |
| cfg_tseg_en | input | 1 | Enables the protected segment |
| cfg_tseg_size | input | 2 | Segment size code |
| cfg_ext_smram | input | 1 | Extended protection enable |
| cfg_tolud | input | 32 | Top of low usable memory (MB aligned, at least 16 MB) |
| out_valid | output | 1 | Decoded request present |
| out_ready | input | 1 | Consumer takes the decoded request |
| out_route | output | 2 | Route code |
| out_addr | output | 32 | Address, zero for invalid |
| out_be | output | 8 | Byte enables, cleared for invalid writes |
| out_write | output | 1 | Write flag |

## Verification
On every cycle, the assertions check the following:
- an invalid route carries address zero, and no byte enables on a write;
- an open hole always routes downstream;
- a disabled segment never yields an invalid route;
- a processor write-back is never neutralised;
- the route code 11 never appears;
- a stalled output stays frozen.

Only the bench's scenarios can show some behaviours. These are the exact segment boundaries for each size code, the split between processor attribute combinations under both extended-protection settings, the decode priority at overlapping boundaries, and the use of configuration captured at acceptance rather than the live value.

// File: rtl/smm_dec_pkg.sv
package smm_dec_pkg;

    localparam int MB_SHIFT = 20;

    typedef enum logic [1:0] {
        SRC_CPU  = 2'b00,
        SRC_PCIE = 2'b01,
        SRC_LINK = 2'b10
    } src_e;

    typedef enum logic [1:0] {
        RT_DRAM  = 2'b00,
        RT_DOWN  = 2'b01,
        RT_INVAL = 2'b10
    } route_e;

    typedef enum logic [1:0] {
        RG_DRAM  = 2'b00,
        RG_HOLE  = 2'b01,
        RG_ABOVE = 2'b10,
        RG_TSEG  = 2'b11
    } region_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_e;

endpackage

// File: rtl/smm_dec_stage.sv
module smm_dec_stage
    import smm_dec_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    stage_e       state_q, state_d;
    logic         take;
    logic [W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // transitions: EMPTY_TO_FULL, FULL_REFILL, FULL_TO_EMPTY, FULL_STALL
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid) state_d = ST_FULL;
            ST_FULL:  if (out_ready && !in_valid) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_EMPTY: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
            end
            ST_FULL: begin
                in_ready  = out_ready;
                out_valid = 1'b1;
            end
            default: begin
                in_ready  = 1'b0;
                out_valid = 1'b0;
            end
        endcase
    end

    assign take = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    data_q <= '0;
        else if (take) data_q <= in_data;
    end

    assign out_data = data_q;

    // R10: a stalled output is frozen
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R10: one-edge latency from acceptance to output
    a_r10_fill: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

endmodule

// File: rtl/smm_dec_region.sv
module smm_dec_region
    import smm_dec_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              hole_en,
    input  logic              tseg_en,
    input  logic [1:0]        tseg_size,
    input  logic [ADDR_W-1:0] tolud,
    output region_e           region
);

    localparam logic [ADDR_W-1:0] HOLE_LO = ADDR_W'(15) << MB_SHIFT;
    localparam logic [ADDR_W-1:0] HOLE_HI = ADDR_W'(16) << MB_SHIFT;
    localparam logic [ADDR_W-1:0] SZ_1M   = ADDR_W'(1) << MB_SHIFT;
    localparam logic [ADDR_W-1:0] SZ_2M   = ADDR_W'(2) << MB_SHIFT;
    localparam logic [ADDR_W-1:0] SZ_8M   = ADDR_W'(8) << MB_SHIFT;

    logic [ADDR_W-1:0] seg_bytes;
    logic [ADDR_W-1:0] seg_base;
    logic              in_hole;

    always_comb begin
        unique case (tseg_size)
            2'b00:   seg_bytes = SZ_1M;
            2'b01:   seg_bytes = SZ_2M;
            default: seg_bytes = SZ_8M;
        endcase
    end

    assign seg_base = tolud - seg_bytes;
    assign in_hole  = hole_en && (addr >= HOLE_LO) && (addr < HOLE_HI);

    always_comb begin
        if (in_hole)                            region = RG_HOLE;
        else if (addr >= tolud)                 region = RG_ABOVE;
        else if (tseg_en && (addr >= seg_base)) region = RG_TSEG;
        else                                    region = RG_DRAM;
    end

endmodule

// File: rtl/smm_dec_route.sv
module smm_dec_route
    import smm_dec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BE_W   = 8
) (
    input  region_e           region,
    input  logic [1:0]        src,
    input  logic              smm,
    input  logic              wb,
    input  logic              write,
    input  logic              ext_smram,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    output logic [1:0]        route,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BE_W-1:0]   be_o
);

    logic inval;

    always_comb begin
        inval = 1'b0;
        route = RT_DRAM;
        unique case (region)
            RG_HOLE, RG_ABOVE: route = RT_DOWN;
            RG_TSEG: begin
                if (src != SRC_CPU)        inval = 1'b1;
                else if (wb)               inval = 1'b0;
                else if (smm && !ext_smram) inval = 1'b0;
                else                       inval = 1'b1;
            end
            default: route = RT_DRAM;
        endcase
        if (inval) route = RT_INVAL;
    end

    always_comb begin
        addr_o = addr;
        be_o   = be;
        if (inval) begin
            addr_o = '0;
            if (write) be_o = '0;
        end
    end

endmodule

// File: rtl/smm_addr_decoder.sv
module smm_addr_decoder
    import smm_dec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [1:0]        in_src,
    input  logic              in_smm,
    input  logic              in_wb,
    input  logic              in_write,
    input  logic [BE_W-1:0]   in_be,
    input  logic              cfg_hole_en,
    input  logic              cfg_tseg_en,
    input  logic [1:0]        cfg_tseg_size,
    input  logic              cfg_ext_smram,
    input  logic [ADDR_W-1:0] cfg_tolud,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_route,
    output logic [ADDR_W-1:0] out_addr,
    output logic [BE_W-1:0]   out_be,
    output logic              out_write
);

    localparam int REQ_W = ADDR_W + 2 + 3 + BE_W;
    localparam int CFG_W = ADDR_W + 5;
    localparam int ST_W  = REQ_W + CFG_W;
    localparam logic [ADDR_W-1:0] HOLE_LO = ADDR_W'(15) << MB_SHIFT;
    localparam logic [ADDR_W-1:0] HOLE_HI = ADDR_W'(16) << MB_SHIFT;

    logic [ST_W-1:0]   st_in, st_out;
    logic [ADDR_W-1:0] q_addr, q_tolud;
    logic [1:0]        q_src, q_size;
    logic              q_smm, q_wb, q_write, q_hole, q_tsen, q_ext;
    logic [BE_W-1:0]   q_be;
    region_e           region;

    // request and configuration are captured together (R11)
    assign st_in = {in_addr, in_src, in_smm, in_wb, in_write, in_be,
                    cfg_hole_en, cfg_tseg_en, cfg_tseg_size, cfg_ext_smram, cfg_tolud};

    smm_dec_stage #(.W(ST_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (st_in),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (st_out)
    );

    assign {q_addr, q_src, q_smm, q_wb, q_write, q_be,
            q_hole, q_tsen, q_size, q_ext, q_tolud} = st_out;

    smm_dec_region #(.ADDR_W(ADDR_W)) u_region (
        .addr      (q_addr),
        .hole_en   (q_hole),
        .tseg_en   (q_tsen),
        .tseg_size (q_size),
        .tolud     (q_tolud),
        .region    (region)
    );

    smm_dec_route #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_route (
        .region    (region),
        .src       (q_src),
        .smm       (q_smm),
        .wb        (q_wb),
        .write     (q_write),
        .ext_smram (q_ext),
        .addr      (q_addr),
        .be        (q_be),
        .route     (out_route),
        .addr_o    (out_addr),
        .be_o      (out_be)
    );

    assign out_write = q_write;

    a_r5_inval_addr: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_route == RT_INVAL |-> out_addr == '0);

    a_r5_inval_be: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_route == RT_INVAL && out_write |-> out_be == '0);

    a_r1_hole: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && q_hole && q_addr >= HOLE_LO && q_addr < HOLE_HI
        |-> out_route == RT_DOWN && out_addr == q_addr);

    a_r4_seg_off: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !q_tsen |-> out_route != RT_INVAL);

    a_r7_cpu_wb: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && q_src == SRC_CPU && q_wb |-> out_route != RT_INVAL);

    a_r8_code: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_route != 2'b11);

endmodule

// File: tb/sim_smm_addr_decoder.sv
`timescale 1ns/1ps
module sim_smm_addr_decoder;

    localparam int AW = 32;
    localparam int BW = 8;
    localparam int MB = 1 << 20;

    typedef struct packed {
        logic [1:0]    route;
        logic [AW-1:0] addr;
        logic [BW-1:0] be;
        logic          wr;
        logic [3:0]    tag;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_smm = 0, in_wb = 0, in_write = 0, out_ready = 0;
    logic [AW-1:0] in_addr = 0, cfg_tolud = AW'(64 * MB);
    logic [1:0] in_src = 0, cfg_tseg_size = 0;
    logic [BW-1:0] in_be = 0;
    logic cfg_hole_en = 0, cfg_tseg_en = 0, cfg_ext_smram = 0;
    logic in_ready, out_valid, out_write;
    logic [1:0] out_route;
    logic [AW-1:0] out_addr;
    logic [BW-1:0] out_be;

    int checks = 0, errors = 0;
    bit done = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    smm_addr_decoder u0 (.*);

    function automatic string tname(input logic [3:0] t);
        case (t)
            1: return "R1"; 2: return "R2"; 4: return "R4"; 5: return "R5";
            6: return "R6"; 7: return "R7"; default: return "R8";
        endcase
    endfunction

    // reference decode written from the requirements
    function automatic exp_t model(input logic [AW-1:0] a, input logic [1:0] s,
        input logic smm, input logic wb, input logic wr, input logic [BW-1:0] be,
        input logic hole, input logic ten, input logic [1:0] sz, input logic ext,
        input logic [AW-1:0] top);
        exp_t e;
        logic [AW-1:0] size;
        logic bad;
        size = (sz == 0) ? AW'(MB) : (sz == 1) ? AW'(2 * MB) : AW'(8 * MB);
        e.addr = a; e.be = be; e.wr = wr; e.route = 2'b00; e.tag = 8;
        if (hole && a >= AW'(15 * MB) && a < AW'(16 * MB)) begin
            e.route = 2'b01; e.tag = 1;
        end else if (a >= top) begin
            e.route = 2'b01; e.tag = 2;
        end else if (a >= top - size) begin
            if (!ten) e.tag = 4;
            else begin
                if (s != 0) begin bad = 1; e.tag = 5; end
                else if (smm) begin bad = !wb && ext; e.tag = 6; end
                else begin bad = !wb; e.tag = 7; end
                if (bad) begin
                    e.route = 2'b10; e.addr = 0;
                    if (wr) e.be = 0;
                end
            end
        end
        return e;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor, sampled 2 ns after each falling edge
    logic prev_acc = 0, prev_stall = 0;
    logic [1:0] s_route; logic [AW-1:0] s_addr; logic [BW-1:0] s_be;
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            exp_t e;
            if (prev_acc) chk(out_valid, "R10", "latency out_valid", out_valid, 1);
            if (prev_stall)
                chk(out_valid && out_route == s_route && out_addr == s_addr && out_be == s_be,
                    "R10", "stall stability", {out_route, out_addr}, {s_route, s_addr});
            chk(in_ready == (!out_valid || out_ready), "R10", "in_ready",
                in_ready, !out_valid || out_ready);
            if (out_valid && out_ready) begin
                if (q.size() == 0) chk(0, "R10", "unexpected output", 1, 0);
                else begin
                    e = q.pop_front();
                    chk(out_route == e.route && out_addr == e.addr && out_be == e.be
                        && out_write == e.wr, tname(e.tag), "decode (R8 codes)",
                        {out_route, out_addr, out_be}, {e.route, e.addr, e.be});
                end
            end
            prev_acc = in_valid && in_ready;
            if (prev_acc)
                q.push_back(model(in_addr, in_src, in_smm, in_wb, in_write, in_be,
                    cfg_hole_en, cfg_tseg_en, cfg_tseg_size, cfg_ext_smram, cfg_tolud));
            prev_stall = out_valid && !out_ready;
            s_route = out_route; s_addr = out_addr; s_be = out_be;
        end
    end

    task automatic req(input logic [AW-1:0] a, input logic [1:0] s, input logic smm,
                       input logic wb, input logic wr, input logic [BW-1:0] be);
        @(negedge clk);
        in_addr = a; in_src = s; in_smm = smm; in_wb = wb; in_write = wr; in_be = be;
        in_valid = 1; out_ready = 1;
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic cfg(input logic h, input logic t, input logic [1:0] sz,
                       input logic x, input int top_mb);
        cfg_hole_en = h; cfg_tseg_en = t; cfg_tseg_size = sz; cfg_ext_smram = x;
        cfg_tolud = AW'(top_mb) * AW'(MB);
    endtask

    initial begin
        void'($urandom(32'h5A17));
        #35;
        chk(!out_valid && in_ready, "R12", "reset state", {out_valid, in_ready}, 2'b01);
        @(negedge clk); rst_n = 1;
        #3 chk(!out_valid && in_ready, "R12", "after reset", {out_valid, in_ready}, 2'b01);

        // R1 hole open / closed, R9 hole ahead of segment
        cfg(1, 1, 2'b00, 0, 64);
        req(AW'(15 * MB), 1, 0, 0, 1, 8'hFF);
        req(AW'(16 * MB) - 1, 0, 0, 0, 0, 8'h0F);
        req(AW'(16 * MB), 0, 0, 0, 0, 8'h0F);
        cfg(0, 1, 2'b00, 0, 64);
        req(AW'(15 * MB) + 4, 2, 0, 0, 1, 8'h3C);
        // R9: hole overlapping the segment (TOLUD 16 MB, 8 MB segment) still goes downstream
        cfg(1, 1, 2'b10, 0, 16);
        req(AW'(15 * MB), 1, 0, 0, 1, 8'hFF);
        req(AW'(14 * MB), 1, 0, 0, 1, 8'hFF);
        // R3 boundaries for each size code, R2 at TOLUD
        for (int sz = 0; sz < 4; sz++) begin
            int mb = (sz == 0) ? 1 : (sz == 1) ? 2 : 8;
            cfg(0, 1, 2'(sz), 0, 64);
            req(AW'((64 - mb) * MB) - 1, 1, 0, 0, 1, 8'hAA);
            req(AW'((64 - mb) * MB), 1, 0, 0, 1, 8'hAA);
            req(AW'(64 * MB) - 8, 2, 0, 0, 0, 8'h55);
            req(AW'(64 * MB), 1, 0, 0, 1, 8'h11);
        end
        // R6/R7 processor attribute combinations under both extended settings
        for (int x = 0; x < 2; x++) begin
            cfg(0, 1, 2'b01, 1'(x), 48);
            for (int k = 0; k < 4; k++) req(AW'(47 * MB), 0, 1'(k >> 1), 1'(k), 1, 8'hF0);
        end
        // R4 segment disabled
        cfg(0, 0, 2'b00, 1, 48);
        req(AW'(47 * MB) + 16, 1, 0, 0, 1, 8'hFF);

        // R11: request waits while configuration changes
        @(negedge clk);
        cfg(0, 1, 2'b00, 0, 32);
        in_addr = AW'(31 * MB); in_src = 1; in_write = 1; in_be = 8'hFF;
        in_valid = 1; out_ready = 0;
        @(negedge clk);
        in_valid = 0;
        cfg(1, 0, 2'b10, 1, 64);
        repeat (3) @(negedge clk);
        out_ready = 1;
        @(negedge clk);

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if ($urandom % 8 == 0)
                cfg(1'($urandom), ($urandom % 4) != 0, 2'($urandom), 1'($urandom),
                    20 + int'($urandom % 44));
            begin
                int m = $urandom % 4;
                logic [AW-1:0] sz;
                sz = (cfg_tseg_size == 0) ? AW'(MB) : (cfg_tseg_size == 1) ? AW'(2 * MB) : AW'(8 * MB);
                case (m)
                    0: in_addr = AW'(14 * MB) + AW'($urandom % (3 * MB));
                    1: in_addr = cfg_tolud - AW'(9 * MB) + AW'($urandom % (10 * MB));
                    2: in_addr = AW'($urandom % (128 * MB));
                    default: case ($urandom % 5)
                        0: in_addr = cfg_tolud - 1;
                        1: in_addr = cfg_tolud;
                        2: in_addr = cfg_tolud - sz;
                        3: in_addr = cfg_tolud - sz - 1;
                        default: in_addr = AW'(16 * MB);
                    endcase
                endcase
            end
            in_src = 2'($urandom); in_smm = 1'($urandom); in_wb = 1'($urandom);
            in_write = 1'($urandom); in_be = 8'($urandom);
            in_valid = ($urandom % 4) != 0;
            out_ready = ($urandom % 3) != 0;
        end
        @(negedge clk);
        in_valid = 0; out_ready = 1;
        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R10", "all requests delivered", q.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R10 watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule